// File: doc/BRIEF.md
# Interval Memory-Reference Bitmap Tracer

The tracer observes a processor's memory access events and condenses them into touched-line bitmaps, one interval of retired instructions at a time. A fixed address window, starting at a programmable base, is divided into equal lines of 16, 32 or 64 bytes. Separate bitmaps record which lines were hit by instruction fetches, data reads and data writes. A bit only records whether its line was touched during the interval, not how often.

When the programmed number of instructions has retired, the finished bitmaps move into a holding bank and are streamed out as 32-bit words over a valid/ready port. A new, empty interval begins on the next cycle, so recording goes on while the previous result drains. If an interval closes before the previous stream has fully drained, the new result is discarded and a sticky overflow flag is raised. Every closed interval advances a sequence number, so a consumer can detect dropped intervals from gaps in the headers.

Top module: `refmap_tracer`

## Requirements
- R1: After reset, `dumpValid`, `dumpLast` and `overflow` are 0.
- R2: An interval closes on the edge that samples the `cfgInterval`-th `instRetired` pulse of that interval, and `dumpValid` is 1 from the next cycle. Before that pulse, no dump starts.
- R3: The line size is 16 bytes for `cfgLineSel`=0, 32 bytes for 1, and 64 bytes for 2 or 3. An address maps to line (addr − cfgBase) / size. Accesses below `cfgBase`, or mapping to line `NUM_LINES` or higher, change no bitmap.
- R4: `accType` encodes 0 = instruction fetch, 1 = data read, 2 = data write. Each type sets a bit only in its own bitmap. Code 3 changes no bitmap.
- R5: A line bit is 1 if its line was touched one or more times by that type within the interval.
- R6: A dump has 1 + 3·NUM_LINES/32 words, in this order:
  - a header word;
  - the fetch bitmap words;
  - the read bitmap words;
  - the write bitmap words.
  Bit j of bitmap word k stands for line 32k+j. `dumpLast` is 1 exactly on the final word.
- R7: While `dumpValid` is 1 and `dumpReady` is 0, `dumpData` and `dumpLast` hold their values. A word advances only when valid and ready are both 1.
- R8: Accesses made while a dump drains are recorded into the next interval. An access in the same cycle as the closing pulse belongs to the interval that closes. Each new interval starts empty.
- R9: If an interval closes while a dump is still draining, `overflow` becomes 1 and stays 1 until reset. That interval's bitmaps are dropped. The port counts as free on the cycle its final word is accepted.
- R10: The header's low bits carry the interval sequence number. It is 0 for the first interval after reset and increments at every interval close, including dropped ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access event present this cycle |
| accAddr | input | ADDR_W | Byte address of the access |
| accType | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| instRetired | input | 1 | One instruction retired this cycle |
| cfgBase | input | ADDR_W | Lowest byte address of the monitored window |
| cfgLineSel | input | 2 | Line size select |
| cfgInterval | input | CNT_W | Interval length in retired instructions |
| dumpValid | output | 1 | Dump word available |
| dumpReady | input | 1 | Consumer accepts the dump word |
| dumpData | output | 32 | Dump word |
| dumpLast | output | 1 | Final word of the dump |
| overflow | output | 1 | Sticky flag: an interval was dropped |

## Verification
The bound checker watches four properties on every cycle:
- the dump port holds steady while stalled;
- `dumpLast` only appears with a valid word;
- overflow, once set, stays set, and it rises only after a retire pulse that met a busy port;
- every dump start follows a retire pulse.

The bench alone can show that bitmap contents are correct: the line arithmetic for each size, the window edges, type separation and the word and bit order. It also covers the exact interval length, where same-cycle accesses are attributed, the dropped interval's missing contents, sequence gaps, and the free-on-last-word hand-off. It does this by comparing whole dumps against bitmaps it computes itself.

// File: rtl/refmap_pkg.sv
package refmap_pkg;

  localparam int WORD_W   = 32;
  localparam int NUM_MAPS = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_NONE  = 2'd3
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic closeIv;   // interval ends this cycle: clear live maps
    logic capture;   // copy live maps into the holding bank
  } ctrlStrobe_t;

endpackage

// File: rtl/refmap_dpath.sv
module refmap_dpath
  import refmap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int WIDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accValid,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [1:0]          accType,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [1:0]          cfgLineSel,
  input  ctrlStrobe_t         strobe,
  input  logic [WIDX_W-1:0]   mapWordIdx,
  output logic [WORD_W-1:0]   mapWord
);

  localparam int LIDX_W        = $clog2(NUM_LINES);
  localparam int WPM           = NUM_LINES / WORD_W;   // NUM_LINES must be a multiple of 32
  localparam int NUM_MAP_WORDS = NUM_MAPS * WPM;

  logic [ADDR_W-1:0]    offset;
  logic [ADDR_W-1:0]    lineWide;
  logic [LIDX_W-1:0]    lineIdx;
  logic                 inWin;
  logic                 hit;
  logic [NUM_LINES-1:0] lineVec;
  logic [WORD_W-1:0]    wordArr [NUM_MAP_WORDS];

  // address to line decode
  always_comb begin
    offset = accAddr - cfgBase;
    unique case (cfgLineSel)
      2'd0:    lineWide = offset >> 4;
      2'd1:    lineWide = offset >> 5;
      default: lineWide = offset >> 6;
    endcase
    inWin   = (accAddr >= cfgBase) && (lineWide < ADDR_W'(NUM_LINES));
    lineIdx = lineWide[LIDX_W-1:0];
    hit     = accValid && inWin && (accType != ACC_NONE);
    lineVec = hit ? (NUM_LINES'(1) << lineIdx) : '0;
  end

  // one live and one held bitmap per access kind
  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
    logic [NUM_LINES-1:0] liveMap;
    logic [NUM_LINES-1:0] heldMap;
    logic [NUM_LINES-1:0] setVec;

    assign setVec = (accType == 2'(m)) ? lineVec : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        liveMap <= '0;
        heldMap <= '0;
      end else begin
        if (strobe.closeIv) liveMap <= '0;
        else                liveMap <= liveMap | setVec;
        if (strobe.capture) heldMap <= liveMap | setVec;
      end
    end

    for (genvar k = 0; k < WPM; k++) begin : g_word
      assign wordArr[m*WPM + k] = heldMap[k*WORD_W +: WORD_W];
    end
  end

  assign mapWord = (int'(mapWordIdx) < NUM_MAP_WORDS) ? wordArr[mapWordIdx] : '0;

endmodule

// File: rtl/refmap_ctrl.sv
module refmap_ctrl
  import refmap_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SEQ_W     = 16,
  parameter int NUM_WORDS = 7,
  parameter int WIDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instRetired,
  input  logic [CNT_W-1:0]  cfgInterval,
  input  logic              dumpReady,
  input  logic [WORD_W-1:0] mapWord,
  output ctrlStrobe_t       strobe,
  output logic [WIDX_W-1:0] mapWordIdx,
  output logic              dumpValid,
  output logic [WORD_W-1:0] dumpData,
  output logic              dumpLast,
  output logic              overflow
);

  logic [CNT_W-1:0]  retCnt;
  logic [CNT_W-1:0]  target;
  logic [SEQ_W-1:0]  seqCnt;
  logic [SEQ_W-1:0]  hdrSeq;
  logic [WIDX_W-1:0] wordIdx;
  logic              validQ;
  logic              ovfQ;
  logic              ivEnd;
  logic              lastWord;
  logic              accept;
  logic              dumpFree;

  always_comb begin
    target   = (cfgInterval == '0) ? CNT_W'(1) : cfgInterval;
    ivEnd    = instRetired && (retCnt >= target - CNT_W'(1));
    lastWord = (wordIdx == WIDX_W'(NUM_WORDS - 1));
    accept   = validQ && dumpReady;
    dumpFree = !validQ || (accept && lastWord);

    strobe.closeIv = ivEnd;
    strobe.capture = ivEnd && dumpFree;

    mapWordIdx = (wordIdx == '0) ? '0 : wordIdx - WIDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retCnt  <= '0;
      seqCnt  <= '0;
      hdrSeq  <= '0;
      wordIdx <= '0;
      validQ  <= 1'b0;
      ovfQ    <= 1'b0;
    end else begin
      retCnt <= ivEnd ? '0 : retCnt + CNT_W'(instRetired);
      seqCnt <= seqCnt + SEQ_W'(ivEnd);
      if (strobe.capture) begin
        hdrSeq  <= seqCnt;
        wordIdx <= '0;
        validQ  <= 1'b1;
      end else if (accept) begin
        wordIdx <= wordIdx + WIDX_W'(1);
        if (lastWord) validQ <= 1'b0;
      end
      if (ivEnd && !dumpFree) ovfQ <= 1'b1;
    end
  end

  assign dumpValid = validQ;
  assign dumpLast  = validQ && lastWord;
  assign dumpData  = (wordIdx == '0) ? WORD_W'(hdrSeq) : mapWord;
  assign overflow  = ovfQ;

endmodule

// File: rtl/refmap_tracer.sv
module refmap_tracer
  import refmap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int CNT_W     = 16,
  parameter int SEQ_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accType,
  input  logic              instRetired,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [1:0]        cfgLineSel,
  input  logic [CNT_W-1:0]  cfgInterval,
  output logic              dumpValid,
  input  logic              dumpReady,
  output logic [31:0]       dumpData,
  output logic              dumpLast,
  output logic              overflow
);

  localparam int NUM_WORDS = 1 + NUM_MAPS * (NUM_LINES / WORD_W);
  localparam int WIDX_W    = $clog2(NUM_WORDS);

  ctrlStrobe_t       strobe;
  logic [WIDX_W-1:0] mapWordIdx;
  logic [WORD_W-1:0] mapWord;

  refmap_ctrl #(
    .CNT_W     (CNT_W),
    .SEQ_W     (SEQ_W),
    .NUM_WORDS (NUM_WORDS),
    .WIDX_W    (WIDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instRetired (instRetired),
    .cfgInterval (cfgInterval),
    .dumpReady   (dumpReady),
    .mapWord     (mapWord),
    .strobe      (strobe),
    .mapWordIdx  (mapWordIdx),
    .dumpValid   (dumpValid),
    .dumpData    (dumpData),
    .dumpLast    (dumpLast),
    .overflow    (overflow)
  );

  refmap_dpath #(
    .ADDR_W    (ADDR_W),
    .NUM_LINES (NUM_LINES),
    .WIDX_W    (WIDX_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accValid   (accValid),
    .accAddr    (accAddr),
    .accType    (accType),
    .cfgBase    (cfgBase),
    .cfgLineSel (cfgLineSel),
    .strobe     (strobe),
    .mapWordIdx (mapWordIdx),
    .mapWord    (mapWord)
  );

endmodule

// File: rtl/refmap_tracer_chk.sv
module refmap_tracer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instRetired,
  input logic        dumpValid,
  input logic        dumpReady,
  input logic [31:0] dumpData,
  input logic        dumpLast,
  input logic        overflow
);

  // R7: a stalled word stays put
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dumpValid && !dumpReady) |=> (dumpValid && $stable(dumpData) && $stable(dumpLast)));

  // R6: the final-word marker only accompanies a valid word
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dumpLast |-> dumpValid);

  // R9: overflow is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: overflow rises only after a retire pulse that met a busy port
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(instRetired && dumpValid));

  // R2: a dump starts only after a retire pulse closed an interval
  p_dump_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dumpValid) |-> $past(instRetired));

endmodule

bind refmap_tracer refmap_tracer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instRetired (instRetired),
  .dumpValid   (dumpValid),
  .dumpReady   (dumpReady),
  .dumpData    (dumpData),
  .dumpLast    (dumpLast),
  .overflow    (overflow)
);

// File: tb/refmap_tracer_tb.sv
`timescale 1ns/1ps
module refmap_tracer_tb;

  localparam int NL  = 64;
  localparam int WPM = NL / 32;
  localparam int NW  = 1 + 3 * WPM;
  localparam int IVL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accType = '0;
  logic        instRetired = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [1:0]  cfgLineSel = '0;
  logic [15:0] cfgInterval = 16'(IVL);
  logic        dumpValid;
  logic        dumpReady = 1'b0;
  logic [31:0] dumpData;
  logic        dumpLast;
  logic        overflow;

  int nChk = 0;
  int nFail = 0;
  int seqNext = 0;
  logic [NL-1:0] cur [3];
  logic [31:0]   expW [NW];

  always #2.5 clk = ~clk;

  refmap_tracer u_dut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accAddr(accAddr),
    .accType(accType), .instRetired(instRetired), .cfgBase(cfgBase),
    .cfgLineSel(cfgLineSel), .cfgInterval(cfgInterval), .dumpValid(dumpValid),
    .dumpReady(dumpReady), .dumpData(dumpData), .dumpLast(dumpLast),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // line number from the requirement's arithmetic, -1 when outside the window
  function automatic int lineOf(input logic [31:0] a);
    int sh = (cfgLineSel == 2'd0) ? 4 : (cfgLineSel == 2'd1) ? 5 : 6;
    logic [31:0] off;
    if (a < cfgBase) return -1;
    off = (a - cfgBase) >> sh;
    if (off >= 32'(NL)) return -1;
    return int'(off);
  endfunction

  function automatic void note(input logic [31:0] a, input logic [1:0] t);
    int i;
    if (t != 2'd3) begin
      i = lineOf(a);
      if (i >= 0) cur[t][i] = 1'b1;
    end
  endfunction

  function automatic void clearCur();
    for (int m = 0; m < 3; m++) cur[m] = '0;
  endfunction

  function automatic void snap();
    expW[0] = 32'(seqNext);
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < WPM; k++)
        expW[1 + m*WPM + k] = cur[m][k*32 +: 32];
    clearCur();
    seqNext++;
  endfunction

  task automatic acc(input logic [31:0] a, input logic [1:0] t);
    accValid = 1'b1; accAddr = a; accType = t;
    note(a, t);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic retire(input int n);
    for (int i = 0; i < n; i++) begin
      instRetired = 1'b1;
      @(negedge clk);
      instRetired = 1'b0;
    end
  endtask

  task automatic retireAcc(input logic [31:0] a, input logic [1:0] t);
    instRetired = 1'b1; accValid = 1'b1; accAddr = a; accType = t;
    note(a, t);
    @(negedge clk);
    instRetired = 1'b0; accValid = 1'b0;
  endtask

  task automatic collect(input bit stall, input bit fireAtLast);
    int k = 0;
    int n = 0;
    bit done = 0;
    while (!done && n < 400) begin
      bit rdy;
      rdy = stall ? (n % 3 == 2) : 1'b1;
      dumpReady = rdy;
      if (dumpValid) begin
        check(dumpData === expW[k],
              k == 0 ? "R10 header sequence" : (rdy ? "R6 word content" : "R7 stalled word"),
              dumpData, expW[k]);
        check(dumpLast === (k == NW-1), "R6 last flag", 32'(dumpLast), 32'(k == NW-1));
        if (rdy) begin
          if (k == NW-1) begin
            done = 1;
            if (fireAtLast) instRetired = 1'b1;
          end
          k++;
        end
      end
      n++;
      @(negedge clk);
    end
    dumpReady = 1'b0;
    instRetired = 1'b0;
    if (!done) check(1'b0, "R7 dump completes", 32'(k), 32'(NW));
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    clearCur();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dumpValid === 1'b0, "R1 valid after reset", 32'(dumpValid), 0);
    check(dumpLast === 1'b0, "R1 last after reset", 32'(dumpLast), 0);
    check(overflow === 1'b0, "R1 overflow after reset", 32'(overflow), 0);

    // T1: 16-byte lines, window edges, duplicates, ignored type (R3 R4 R5)
    cfgBase = 32'h0000_1000; cfgLineSel = 2'd0;
    acc(32'h1000, 2'd0);
    acc(32'h1005, 2'd0);
    acc(32'h13F0, 2'd1);
    acc(32'h1400, 2'd2);
    acc(32'h0FFF, 2'd2);
    acc(32'h1020, 2'd3);
    acc(32'h1230, 2'd2);
    acc(32'h1230, 2'd1);
    retire(IVL - 1);
    check(dumpValid === 1'b0, "R2 no dump before last pulse", 32'(dumpValid), 0);
    retire(1);
    check(dumpValid === 1'b1, "R2 dump after last pulse", 32'(dumpValid), 1);
    snap();
    collect(1'b0, 1'b0);   // R3 R4 R5 checked through the word compare

    // T2: sweep all line-size codes over every line (R3 R4 R6 R7)
    for (int sel = 0; sel < 4; sel++) begin
      int sz = (sel == 0) ? 16 : (sel == 1) ? 32 : 64;
      cfgLineSel = 2'(sel);
      cfgBase = 32'h0002_0000 + 32'(sel) * 32'h0000_2000;
      for (int i = 0; i < NL; i++)
        acc(cfgBase + 32'(i * sz + (i % sz)), 2'((i + sel) % 3));
      acc(cfgBase + 32'(NL * sz), 2'd0);
      acc(cfgBase - 32'd1, 2'd1);
      retire(IVL);
      snap();
      collect(sel[0], 1'b0);
    end

    // T3: recording during a dump, same-cycle attribution (R8)
    cfgLineSel = 2'd1; cfgBase = 32'h0000_4000;
    acc(32'h4000, 2'd0);
    retire(IVL - 1);
    retireAcc(32'h4020, 2'd2);
    snap();
    acc(32'h4040, 2'd1);
    acc(32'h47E0, 2'd0);
    check(dumpValid === 1'b1, "R8 dump still pending", 32'(dumpValid), 1);
    collect(1'b1, 1'b0);
    retire(IVL);
    snap();
    collect(1'b0, 1'b0);

    // T4: port free on the cycle its final word is accepted (R9)
    acc(32'h4100, 2'd2);
    retire(IVL);
    snap();
    acc(32'h4200, 2'd0);
    retire(IVL - 1);
    collect(1'b0, 1'b1);
    check(dumpValid === 1'b1, "R9 back-to-back dump starts", 32'(dumpValid), 1);
    check(overflow === 1'b0, "R9 no overflow at final accept", 32'(overflow), 0);
    check(dumpData === 32'(seqNext), "R10 back-to-back header", dumpData, 32'(seqNext));
    snap();
    collect(1'b0, 1'b0);

    // T5: overflow drops an interval and leaves a sequence gap (R9 R10)
    acc(32'h4300, 2'd1);
    retire(IVL);
    snap();
    acc(32'h4400, 2'd2);
    retire(IVL - 1);
    check(overflow === 1'b0, "R9 no overflow yet", 32'(overflow), 0);
    retire(1);
    check(overflow === 1'b1, "R9 overflow on busy close", 32'(overflow), 1);
    clearCur();
    seqNext++;
    collect(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(overflow === 1'b1, "R9 overflow sticky", 32'(overflow), 1);
    acc(32'h4500, 2'd0);
    retire(IVL);
    snap();
    collect(1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule